// File: doc/BRIEF.md
# Boosted Cascade Window Classifier

This block decides whether one candidate search window holds an object. It walks a cascade of boosted stages. Each stage is a run of rectangle features. For every feature, a producer delivers the rectangle sums of the window on a valid/ready input. The block weights those sums and compares the result with the feature's trained threshold, after scaling that threshold by the window's variance. It then adds one of two trained leaf values to a running stage sum. When a stage's features are done, the stage sum is checked against the stage threshold. A failing stage ends the window at once. A window that clears every stage is flagged as a detection candidate.

Classifier parameters sit in two preloaded memories outside the block, each read with one cycle of latency. The stage memory holds a feature count and a threshold for each stage. The feature memory holds the feature records, stored back to back in evaluation order. The block drives both read addresses itself. Each window yields one verdict: a pass flag and the index of the stage that rejected it (or the last stage, on a pass). The verdict is held until the consumer takes it. Only then is another window admitted.

Top module: `cascade_window_classifier`

## Requirements
- R1: A feature record holds weights w0 (bits 15:0), w1 (31:16) and w2 (47:32), and a three-rectangle flag in bit 96. The feature value is rs_sum0*w0 + rs_sum1*w1, plus rs_sum2*w2 only when the flag is 1. For a two-rectangle feature, rs_sum2 has no effect.
- R2: The feature threshold (bits 63:48, signed) is multiplied by win_var, which is unsigned. If the feature value is strictly greater than this product, the leaf in bits 95:80 is added to the stage sum. Otherwise the leaf in bits 79:64 is added.
- R3: The stage sum starts at zero for every stage. A stage passes when its sum is greater than or equal to the signed stage threshold in stage-record bits 15:0. It fails when the sum is below that threshold.
- R4: At the first failing stage, the block reports res_pass=0 and res_stage equal to that stage's index. It takes no further rectangle-sum beats for that window.
- R5: A window that passes every stage is reported with res_pass=1 and res_stage=NUM_STAGES-1.
- R6: Features are read in address order starting at 0 for each window. A stage uses the number of features given in the stage-record bits above the threshold. Each accepted beat uses the feature at the current feat_addr. A stage whose count is 0 is judged with a sum of 0.
- R7: The feature value saturates at the signed 48-bit limits instead of wrapping, and so does the stage sum.
- R8: The result is held stable while res_valid is high and res_ready is low. win_ready stays low while a result is pending or a window is in progress.
- R9: During and after reset, res_valid=0, rs_ready=0 and win_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | New window offered |
| win_ready | output | 1 | Block can take a new window |
| win_var | input | COEF_W | Unsigned variance value of the window |
| rs_valid | input | 1 | Rectangle sums for the current feature present |
| rs_ready | output | 1 | Block takes rectangle sums this cycle |
| rs_sum0 | input | SUM_W | First rectangle sum, signed |
| rs_sum1 | input | SUM_W | Second rectangle sum, signed |
| rs_sum2 | input | SUM_W | Third rectangle sum, signed |
| feat_addr | output | clog2(NUM_FEATS) | Feature memory read address |
| feat_rdata | input | 6*COEF_W+1 | Feature record, one cycle after the address |
| stg_addr | output | clog2(NUM_STAGES) | Stage memory read address |
| stg_rdata | input | clog2(NUM_FEATS)+1+COEF_W | Stage record {count, threshold} |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict |
| res_pass | output | 1 | Window passed every stage |
| res_stage | output | clog2(NUM_STAGES) | Rejecting stage, or last stage on a pass |

## Verification
The bench places feature values exactly on the scaled threshold and stage sums exactly on the stage threshold. A design that used >= for features, or > for stages, would flip those verdicts. Some stimulus gives a two-rectangle feature a large third sum. Other stimulus gives a three-rectangle feature third terms that cancel. A design that mixed up the flag would then pass windows it should reject. Full-scale rectangle sums push the weighted value past the 48-bit range in both directions, so a wrapping adder would reverse the decision. A variance at its largest unsigned value catches a design that treats it as signed. The bench also counts the beats each window consumes and checks the address of each beat. A design that kept evaluating after a failure, restarted the feature pointer at each stage, or mishandled a stage with no features would show up there.

// File: rtl/cascade_window_classifier.sv
`timescale 1ns/1ps
module cascade_window_classifier #(
  parameter int NUM_STAGES = 22,
  parameter int NUM_FEATS  = 2135,
  parameter int SUM_W      = 32,
  parameter int COEF_W     = 16,
  parameter int ACC_W      = 48,
  localparam int STG_W  = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int FA_W   = (NUM_FEATS > 1) ? $clog2(NUM_FEATS) : 1,
  localparam int CNT_W  = FA_W + 1,
  localparam int FREC_W = 6 * COEF_W + 1,
  localparam int SREC_W = CNT_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     win_valid,
  output logic                     win_ready,
  input  logic [COEF_W-1:0]        win_var,
  input  logic                     rs_valid,
  output logic                     rs_ready,
  input  logic signed [SUM_W-1:0]  rs_sum0,
  input  logic signed [SUM_W-1:0]  rs_sum1,
  input  logic signed [SUM_W-1:0]  rs_sum2,
  output logic [FA_W-1:0]          feat_addr,
  input  logic [FREC_W-1:0]        feat_rdata,
  output logic [STG_W-1:0]         stg_addr,
  input  logic [SREC_W-1:0]        stg_rdata,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic                     res_pass,
  output logic [STG_W-1:0]         res_stage
);

  localparam int PROD_W = SUM_W + COEF_W;
  localparam int FSUM_W = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NUM_STAGES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SREQ, S_SLOAD, S_FREQ, S_FEAT, S_SCHK} state_t;

  state_t                    state;
  logic [COEF_W-1:0]         var_q;
  logic [STG_W-1:0]          stage;
  logic [FA_W-1:0]           ptr;
  logic [CNT_W-1:0]          left;
  logic signed [COEF_W-1:0]  stg_thr;
  logic signed [ACC_W-1:0]   acc;

  logic signed [COEF_W-1:0] f_w0, f_w1, f_w2, f_thr, f_lo, f_hi;
  logic                     f_three;
  assign f_w0    = feat_rdata[COEF_W-1:0];
  assign f_w1    = feat_rdata[2*COEF_W-1:COEF_W];
  assign f_w2    = feat_rdata[3*COEF_W-1:2*COEF_W];
  assign f_thr   = feat_rdata[4*COEF_W-1:3*COEF_W];
  assign f_lo    = feat_rdata[5*COEF_W-1:4*COEF_W];
  assign f_hi    = feat_rdata[6*COEF_W-1:5*COEF_W];
  assign f_three = feat_rdata[6*COEF_W];

  logic [CNT_W-1:0]         stg_cnt_in;
  logic signed [COEF_W-1:0] stg_thr_in;
  assign stg_cnt_in = stg_rdata[SREC_W-1:COEF_W];
  assign stg_thr_in = stg_rdata[COEF_W-1:0];

  assign feat_addr = ptr;
  assign stg_addr  = stage;
  assign rs_ready  = (state == S_FEAT);
  assign win_ready = (state == S_IDLE) && !res_valid;

  logic beat;
  assign beat = rs_valid && rs_ready;

  logic signed [PROD_W-1:0] p0, p1, p2, p2m;
  logic signed [FSUM_W-1:0] fsum;
  logic signed [ACC_W-1:0]  fval, sthr;
  logic                     take_hi;
  logic signed [COEF_W-1:0] leaf;
  logic signed [ACC_W:0]    asum;
  logic signed [ACC_W-1:0]  acc_next;
  logic                     stage_ok;

  assign p0   = PROD_W'(rs_sum0) * PROD_W'(f_w0);
  assign p1   = PROD_W'(rs_sum1) * PROD_W'(f_w1);
  assign p2   = PROD_W'(rs_sum2) * PROD_W'(f_w2);
  assign p2m  = f_three ? p2 : '0;
  assign fsum = FSUM_W'(p0) + FSUM_W'(p1) + FSUM_W'(p2m);
  assign fval = (fsum > FSUM_W'(SAT_MAX)) ? SAT_MAX :
                (fsum < FSUM_W'(SAT_MIN)) ? SAT_MIN : fsum[ACC_W-1:0];
  assign sthr = ACC_W'(f_thr) * ACC_W'($signed({1'b0, var_q}));
  assign take_hi = fval > sthr;
  assign leaf = take_hi ? f_hi : f_lo;

  assign asum = (ACC_W+1)'(acc) + (ACC_W+1)'(leaf);
  assign acc_next = (asum > (ACC_W+1)'(SAT_MAX)) ? SAT_MAX :
                    (asum < (ACC_W+1)'(SAT_MIN)) ? SAT_MIN : asum[ACC_W-1:0];
  assign stage_ok = acc >= ACC_W'(stg_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      var_q     <= '0;
      stage     <= '0;
      ptr       <= '0;
      left      <= '0;
      stg_thr   <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_stage <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (state)
        S_IDLE: if (win_valid && win_ready) begin
          var_q <= win_var;
          stage <= '0;
          ptr   <= '0;
          state <= S_SREQ;
        end
        S_SREQ: state <= S_SLOAD;
        S_SLOAD: begin
          stg_thr <= stg_thr_in;
          left    <= stg_cnt_in;
          acc     <= '0;
          state   <= (stg_cnt_in == '0) ? S_SCHK : S_FREQ;
        end
        S_FREQ: state <= S_FEAT;
        S_FEAT: if (beat) begin
          acc   <= acc_next;
          ptr   <= ptr + 1'b1;
          left  <= left - 1'b1;
          state <= (left == CNT_W'(1)) ? S_SCHK : S_FREQ;
        end
        S_SCHK: begin
          if (!stage_ok || stage == LAST_STG) begin
            res_valid <= 1'b1;
            res_pass  <= stage_ok;
            res_stage <= stage;
            state     <= S_IDLE;
          end else begin
            stage <= stage + 1'b1;
            state <= S_SREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pass) && $stable(res_stage)));

  assert_no_window_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !win_ready);

  assert_pass_reports_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pass) |-> (res_stage == LAST_STG));

  assert_no_beat_after_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rs_ready);

  assert_stage_sum_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !leaf[COEF_W-1]) |=> (acc >= $past(acc)));

endmodule

// File: tb/test_cascade_window_classifier.sv
`timescale 1ns/1ps
module test_cascade_window_classifier;
  localparam int NS = 3, NF = 8, CW = 16, SW = 32, AW = 48;
  localparam int STW = $clog2(NS), FAW = $clog2(NF), CNTW = FAW + 1;
  localparam int FRW = 6 * CW + 1, SRW = CNTW + CW;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_valid = 1'b0, rs_valid = 1'b0, res_ready = 1'b0;
  logic [CW-1:0] win_var = '0;
  logic signed [SW-1:0] rs_sum0 = '0, rs_sum1 = '0, rs_sum2 = '0;
  logic win_ready, rs_ready, res_valid, res_pass;
  logic [FAW-1:0] feat_addr;
  logic [STW-1:0] stg_addr, res_stage;
  logic [FRW-1:0] feat_rdata;
  logic [SRW-1:0] stg_rdata;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  cascade_window_classifier #(.NUM_STAGES(NS), .NUM_FEATS(NF), .SUM_W(SW),
    .COEF_W(CW), .ACC_W(AW)) i_cascade_window_classifier (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_var(win_var), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_sum0(rs_sum0), .rs_sum1(rs_sum1), .rs_sum2(rs_sum2),
    .feat_addr(feat_addr), .feat_rdata(feat_rdata), .stg_addr(stg_addr),
    .stg_rdata(stg_rdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_pass(res_pass), .res_stage(res_stage));

  // feature record {three, hi, lo, thr, w2, w1, w0}
  function automatic logic [FRW-1:0] feat_rec(input logic [FAW-1:0] a);
    case (a)
      0: return {1'b0, 16'd8, 16'd3, 16'd2, 16'd5, 16'hFFFF, 16'd1};
      1: return {1'b1, 16'd6, 16'hFFFC, 16'd1, 16'hFFFE, 16'd1, 16'd1};
      2: return {1'b1, 16'd5, 16'd0, 16'd10, 16'h7FFF, 16'h7FFF, 16'h7FFF};
      default: return '0;
    endcase
  endfunction

  function automatic logic [SRW-1:0] stage_rec(input logic [STW-1:0] s);
    case (s)
      0: return {CNTW'(2), 16'd14};
      1: return {CNTW'(1), 16'd5};
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    feat_rdata <= feat_rec(feat_addr);
    stg_rdata  <= stage_rec(stg_addr);
  end

  localparam int VAR_T [NV] = '{1, 1, 3, 3, 0, 1, 0, 0, 65535};
  localparam int S_T [NV][9] = '{
    '{10, 5, -999, 3, 4, 1, 1, 0, 0},
    '{10, 5, 0, 1, 1, 1, 0, 0, 0},
    '{7, 1, 0, 10, 0, 0, 0, 0, 0},
    '{8, 1, 0, 10, 0, 0, 0, 0, 0},
    '{1, 0, 0, 1, 0, 0, 1, 0, 0},
    '{5, 0, 0, 5, 5, 5, 0, 0, 0},
    '{1, 0, 0, 1, 0, 0, 32'sh7FFFFFFF, 32'sh7FFFFFFF, 32'sh7FFFFFFF},
    '{1, 0, 0, 1, 0, 0, 32'sh80000000, 32'sh80000000, 32'sh80000000},
    '{100000, 0, 0, 70000, 0, 0, 0, 0, 0}};
  localparam int EPASS [NV]  = '{1, 0, 0, 0, 1, 0, 1, 0, 0};
  localparam int ESTG [NV]   = '{2, 0, 0, 1, 2, 0, 2, 1, 0};
  localparam int EBEATS [NV] = '{3, 2, 2, 3, 3, 2, 3, 3, 2};
  string vec_tag [NV] = '{"R1 R3 R5", "R2 R4", "R2 strict", "R3 R4", "R5 R6 count0",
                          "R1 R4", "R7 high", "R7 low", "R2 unsigned var"};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_beat(input int i, input int b);
    rs_sum0 = S_T[i][3*b];
    rs_sum1 = S_T[i][3*b+1];
    rs_sum2 = S_T[i][3*b+2];
  endtask

  task automatic run_window(input int i, input bit hold_test);
    int beats = 0;
    bit xfer;
    @(negedge clk);
    win_var = CW'(VAR_T[i]);
    win_valid = 1'b1;
    for (int g = 0; g < 100 && !win_ready; g++) @(negedge clk);
    @(posedge clk); #1;
    win_valid = 1'b0;
    load_beat(i, 0);
    rs_valid = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (res_valid) break;
      xfer = rs_valid && rs_ready;
      if (xfer) chk(feat_addr == FAW'(beats), "R6 feature address", feat_addr, beats);
      @(posedge clk); #1;
      if (xfer) begin
        beats++;
        if (beats < 3) load_beat(i, beats);
        else rs_valid = 1'b0;
      end
    end
    rs_valid = 1'b0;
    chk(res_valid, {vec_tag[i], " verdict present"}, res_valid, 1);
    chk(res_pass == EPASS[i][0], {vec_tag[i], " pass flag"}, res_pass, EPASS[i]);
    chk(res_stage == STW'(ESTG[i]), {vec_tag[i], " stage index"}, res_stage, ESTG[i]);
    chk(beats == EBEATS[i], {vec_tag[i], " R4 beats consumed"}, beats, EBEATS[i]);
    if (hold_test) begin
      win_valid = 1'b1;
      rs_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(res_valid && res_pass == EPASS[i][0] && res_stage == STW'(ESTG[i]),
            "R8 verdict held", {res_valid, res_pass}, {1'b1, EPASS[i][0]});
        chk(!win_ready, "R8 no window while pending", win_ready, 0);
        chk(!rs_ready, "R4 no beat while pending", rs_ready, 0);
      end
      win_valid = 1'b0;
      rs_valid = 1'b0;
    end
    @(negedge clk);
    res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
    @(negedge clk);
    chk(!res_valid && win_ready, "R8 released after accept", {res_valid, win_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid && !rs_ready && win_ready, "R9 in reset",
        {res_valid, rs_ready, win_ready}, 3'b001);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && !rs_ready && win_ready, "R9 after reset",
        {res_valid, rs_ready, win_ready}, 3'b001);
    for (int i = 0; i < NV; i++) run_window(i, 1'b0);
    run_window(3, 1'b1);
    run_window(6, 1'b1);
    run_window(0, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule